// File: doc/BRIEF.md
# Condition Register and Branch Evaluator

This block holds a 32-bit condition register made of eight 4-bit fields and decides whether a branch is taken. Each field records a relation between two numbers: less than, greater than, equal, plus a fourth summary-overflow/unordered bit. Three write sources update the register:

- Record-form integer results always land in field 0.
- Floating-point exception status always lands in field 1.
- Compare operations land in any field, chosen by a 3-bit index.

The compare logic handles signed and unsigned operands. The fourth bit is copied from a sticky overflow input.

The branch evaluator names a single register bit, 0 to 31, with bit 0 being the most significant bit of field 0. The branch resolves as taken when that bit is 1. An unconditional branch is always taken. The decision is registered. It appears one clock after the request and uses the register contents as they stood before that clock's writes.

Top module: `cond_reg_unit`

## Requirements
- R1: After a synchronous active-high reset, `cr_value` reads 0 and `br_resolved` and `br_taken` read 0.
- R2: Field f occupies `cr_value[31-4f : 28-4f]`. Inside a field, from the most significant bit down, the bits are LT, GT, EQ, SO.
- R3: A signed compare (`cmp_signed`=1) of `cmp_a` against `cmp_b` sets exactly one of LT, GT or EQ. SO is copied from `cmp_so`.
- R4: An unsigned compare (`cmp_signed`=0) orders the operands as unsigned numbers. For example, all-ones against 1 yields GT.
- R5: When `rec_valid` is 1, field 0 takes LT if `rec_result` is negative, GT if it is positive and non-zero, and EQ if it is zero, with SO = `rec_ovf`. When `rec_valid` is 0, field 0 is not touched by this source.
- R6: When `fpx_valid` is 1, field 1 is loaded with `fpx_status` verbatim, with `fpx_status[3]` going to the LT position.
- R7: When `cmp_valid` is 1, only the field indexed by `cmp_field` takes the compare result. With no write valid, the register holds its value.
- R8: A compare write to field 0 or 1 wins over a record-form or floating-point write to the same field in the same cycle. Writes to different fields in one cycle all take effect.
- R9: With `br_valid`=1 and `br_uncond`=0, `br_taken` on the next cycle equals bit `br_bit` of the register (bit 0 = MSB), as the register stood before that edge's writes.
- R10: With `br_valid`=1 and `br_uncond`=1, `br_taken` is 1 on the next cycle whatever the register holds.
- R11: `br_resolved` is 1 exactly in the cycle after a cycle with `br_valid`=1. `br_taken` is 0 whenever `br_resolved` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_valid | input | 1 | Record-form result present |
| rec_result | input | 32 | Integer result to classify into field 0 |
| rec_ovf | input | 1 | Sticky overflow for field 0 |
| fpx_valid | input | 1 | Floating-point status present |
| fpx_status | input | 4 | Value written to field 1 |
| cmp_valid | input | 1 | Compare operation present |
| cmp_field | input | 3 | Target field of the compare |
| cmp_signed | input | 1 | 1 = signed compare, 0 = unsigned |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| cmp_so | input | 1 | Sticky overflow copied into the fourth bit |
| br_valid | input | 1 | Branch evaluation request |
| br_uncond | input | 1 | Branch is unconditional |
| br_bit | input | 5 | Register bit tested, 0 = MSB |
| cr_value | output | 32 | Current register contents |
| br_resolved | output | 1 | Branch decision valid this cycle |
| br_taken | output | 1 | Branch decision |

## Verification
The bench targets the operand pairs where signed and unsigned order disagree. A design that ignored the mode would report LT for an all-ones operand that should compare greater. It walks every one of the 32 bit positions through the branch evaluator, so a little-endian bit selection or a swapped field order gives wrong decisions at the mismatched bits. Same-cycle collisions on field 0 and field 1 are driven, and a wrong priority leaves the record or exception value in place of the compare result. A branch is issued in the same cycle as a write to the bit it tests; a design that forwarded the new value would resolve to the updated bit rather than the old one.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int FIELD_W   = 4;
  localparam int NUM_FIELD = 8;
  localparam int CR_W      = FIELD_W * NUM_FIELD;
  localparam int IDX_W     = $clog2(NUM_FIELD);
  localparam int BIT_IDX_W = $clog2(CR_W);
  localparam int REC_FIELD = 0;
  localparam int FPX_FIELD = 1;

  typedef logic [FIELD_W-1:0] field_t;
  typedef logic [0:NUM_FIELD-1][FIELD_W-1:0] cr_t;
endpackage

// File: rtl/cr_compare.sv
module cr_compare #(
  parameter int W = 32
) (
  input  logic [W-1:0]             a,
  input  logic [W-1:0]             b,
  input  logic                     is_signed,
  input  logic                     so,
  output logic [cr_pkg::FIELD_W-1:0] flags
);
  logic lt, gt, eq;

  always_comb begin
    if (is_signed) begin
      lt = $signed(a) < $signed(b);
      gt = $signed(a) > $signed(b);
    end else begin
      lt = a < b;
      gt = a > b;
    end
    eq    = (a == b);
    flags = {lt, gt, eq, so};
  end

  always_comb begin
    p_one_relation_r3: assert ($onehot({lt, gt, eq}));
  end
endmodule

// File: rtl/cr_field_bank.sv
module cr_field_bank
  import cr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rec_valid,
  input  field_t           rec_flags,
  input  logic             fpx_valid,
  input  field_t           fpx_flags,
  input  logic             cmp_valid,
  input  logic [IDX_W-1:0] cmp_idx,
  input  field_t           cmp_flags,
  output cr_t              cr_q
);
  for (genvar f = 0; f < NUM_FIELD; f++) begin : g_field
    logic cmp_hit;
    assign cmp_hit = cmp_valid && (cmp_idx == IDX_W'(f));

    always_ff @(posedge clk) begin
      if (rst)
        cr_q[f] <= '0;
      else if (cmp_hit)
        cr_q[f] <= cmp_flags;
      else if ((f == REC_FIELD) && rec_valid)
        cr_q[f] <= rec_flags;
      else if ((f == FPX_FIELD) && fpx_valid)
        cr_q[f] <= fpx_flags;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (cr_q == '0));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(rec_valid || fpx_valid || cmp_valid) |=> $stable(cr_q));

  p_cmp_lands_r8: assert property (@(posedge clk) disable iff (rst)
    cmp_valid |=> cr_q[$past(cmp_idx)] == $past(cmp_flags));

  p_rec_lands_r5: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !(cmp_valid && cmp_idx == IDX_W'(REC_FIELD)))
      |=> cr_q[REC_FIELD] == $past(rec_flags));

  p_fpx_lands_r6: assert property (@(posedge clk) disable iff (rst)
    (fpx_valid && !(cmp_valid && cmp_idx == IDX_W'(FPX_FIELD)))
      |=> cr_q[FPX_FIELD] == $past(fpx_flags));
endmodule

// File: rtl/cr_branch_eval.sv
module cr_branch_eval
  import cr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CR_W-1:0]      cr_flat,
  input  logic                 br_valid,
  input  logic                 br_uncond,
  input  logic [BIT_IDX_W-1:0] br_bit,
  output logic                 br_resolved,
  output logic                 br_taken
);
  logic sel_bit;
  assign sel_bit = cr_flat[(CR_W-1) - int'(br_bit)];

  always_ff @(posedge clk) begin
    if (rst) begin
      br_resolved <= 1'b0;
      br_taken    <= 1'b0;
    end else begin
      br_resolved <= br_valid;
      br_taken    <= br_valid && (br_uncond || sel_bit);
    end
  end

  p_uncond_taken_r10: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_uncond) |=> br_taken);

  p_resolve_follows_r11: assert property (@(posedge clk) disable iff (rst)
    br_valid |=> br_resolved);

  p_quiet_when_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !br_valid |=> !br_resolved && !br_taken);
endmodule

// File: rtl/cond_reg_unit.sv
module cond_reg_unit
  import cr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rec_valid,
  input  logic [DATA_W-1:0]    rec_result,
  input  logic                 rec_ovf,
  input  logic                 fpx_valid,
  input  logic [FIELD_W-1:0]   fpx_status,
  input  logic                 cmp_valid,
  input  logic [IDX_W-1:0]     cmp_field,
  input  logic                 cmp_signed,
  input  logic [DATA_W-1:0]    cmp_a,
  input  logic [DATA_W-1:0]    cmp_b,
  input  logic                 cmp_so,
  input  logic                 br_valid,
  input  logic                 br_uncond,
  input  logic [BIT_IDX_W-1:0] br_bit,
  output logic [CR_W-1:0]      cr_value,
  output logic                 br_resolved,
  output logic                 br_taken
);
  field_t rec_flags, cmp_flags;
  cr_t    cr_q;

  cr_compare #(.W(DATA_W)) u_rec_cls (
    .a(rec_result), .b('0), .is_signed(1'b1), .so(rec_ovf), .flags(rec_flags)
  );

  cr_compare #(.W(DATA_W)) u_cmp (
    .a(cmp_a), .b(cmp_b), .is_signed(cmp_signed), .so(cmp_so), .flags(cmp_flags)
  );

  cr_field_bank u_bank (
    .clk(clk), .rst(rst),
    .rec_valid(rec_valid), .rec_flags(rec_flags),
    .fpx_valid(fpx_valid), .fpx_flags(fpx_status),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_field), .cmp_flags(cmp_flags),
    .cr_q(cr_q)
  );

  assign cr_value = cr_q;

  cr_branch_eval u_br (
    .clk(clk), .rst(rst), .cr_flat(cr_value),
    .br_valid(br_valid), .br_uncond(br_uncond), .br_bit(br_bit),
    .br_resolved(br_resolved), .br_taken(br_taken)
  );
endmodule

// File: tb/cond_reg_unit_bench.sv
module cond_reg_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        rec_valid, rec_ovf, fpx_valid, cmp_valid, cmp_signed, cmp_so;
  logic        br_valid, br_uncond;
  logic [31:0] rec_result, cmp_a, cmp_b, cr_value;
  logic [3:0]  fpx_status;
  logic [2:0]  cmp_field;
  logic [4:0]  br_bit;
  logic        br_resolved, br_taken;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_cr;

  always #4 clk = ~clk;

  cond_reg_unit u_cond_reg_unit (
    .clk(clk), .rst(rst),
    .rec_valid(rec_valid), .rec_result(rec_result), .rec_ovf(rec_ovf),
    .fpx_valid(fpx_valid), .fpx_status(fpx_status),
    .cmp_valid(cmp_valid), .cmp_field(cmp_field), .cmp_signed(cmp_signed),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_so(cmp_so),
    .br_valid(br_valid), .br_uncond(br_uncond), .br_bit(br_bit),
    .cr_value(cr_value), .br_resolved(br_resolved), .br_taken(br_taken)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] put_field(logic [31:0] cr, int f, logic [3:0] v);
    logic [31:0] r = cr;
    r[31-4*f -: 4] = v;
    return r;
  endfunction

  task automatic idle();
    rec_valid = 0; rec_result = 0; rec_ovf = 0;
    fpx_valid = 0; fpx_status = 0;
    cmp_valid = 0; cmp_field = 0; cmp_signed = 0; cmp_a = 0; cmp_b = 0; cmp_so = 0;
    br_valid = 0; br_uncond = 0; br_bit = 0;
  endtask

  // inputs are set after a negedge; step lets one posedge pass and returns at the next negedge
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    rst = 1; idle();
    @(negedge clk); @(negedge clk);
    rst = 0;
    exp_cr = 0;
    chk("R1 cr", cr_value, 0);
    chk("R1 resolved", {31'd0, br_resolved}, 0);
    chk("R1 taken", {31'd0, br_taken}, 0);
  endtask

  task automatic t_record();
    rec_valid = 1; rec_result = 32'hFFFF_FFFB; step();
    exp_cr = put_field(exp_cr, 0, 4'b1000);
    chk("R5 negative R2", cr_value, exp_cr);
    rec_valid = 1; rec_result = 0; rec_ovf = 1; step();
    exp_cr = put_field(exp_cr, 0, 4'b0011);
    chk("R5 zero ovf", cr_value, exp_cr);
    rec_valid = 1; rec_result = 7; step();
    exp_cr = put_field(exp_cr, 0, 4'b0100);
    chk("R5 positive", cr_value, exp_cr);
    rec_valid = 0; rec_result = 0; step();
    chk("R5 not valid ignored", cr_value, exp_cr);
  endtask

  task automatic t_fpx();
    fpx_valid = 1; fpx_status = 4'b1010; step();
    exp_cr = put_field(exp_cr, 1, 4'b1010);
    chk("R6 fp field", cr_value, exp_cr);
  endtask

  task automatic t_compare();
    cmp_valid = 1; cmp_field = 5; cmp_signed = 1; cmp_a = 32'hFFFF_FFFF; cmp_b = 1; step();
    exp_cr = put_field(exp_cr, 5, 4'b1000);
    chk("R3 signed lt R7", cr_value, exp_cr);
    cmp_valid = 1; cmp_field = 6; cmp_signed = 0; cmp_a = 32'hFFFF_FFFF; cmp_b = 1; cmp_so = 1; step();
    exp_cr = put_field(exp_cr, 6, 4'b0101);
    chk("R4 unsigned gt so", cr_value, exp_cr);
    cmp_valid = 1; cmp_field = 7; cmp_signed = 1; cmp_a = 32'h1234; cmp_b = 32'h1234; step();
    exp_cr = put_field(exp_cr, 7, 4'b0010);
    chk("R3 equal", cr_value, exp_cr);
    cmp_valid = 1; cmp_field = 2; cmp_signed = 0; cmp_a = 3; cmp_b = 9; cmp_so = 1; step();
    exp_cr = put_field(exp_cr, 2, 4'b1001);
    chk("R4 unsigned lt", cr_value, exp_cr);
    step();
    chk("R7 idle hold", cr_value, exp_cr);
  endtask

  task automatic t_priority();
    rec_valid = 1; rec_result = 0;
    cmp_valid = 1; cmp_field = 0; cmp_signed = 1; cmp_a = 1; cmp_b = 2; step();
    exp_cr = put_field(exp_cr, 0, 4'b1000);
    chk("R8 cmp beats record", cr_value, exp_cr);
    fpx_valid = 1; fpx_status = 4'b0111;
    cmp_valid = 1; cmp_field = 1; cmp_signed = 1; cmp_a = 5; cmp_b = 2; step();
    exp_cr = put_field(exp_cr, 1, 4'b0100);
    chk("R8 cmp beats fp", cr_value, exp_cr);
    rec_valid = 1; rec_result = 32'h8000_0000; fpx_valid = 1; fpx_status = 4'b0001;
    cmp_valid = 1; cmp_field = 3; cmp_signed = 0; cmp_a = 8; cmp_b = 8; step();
    exp_cr = put_field(exp_cr, 0, 4'b1000);
    exp_cr = put_field(exp_cr, 1, 4'b0001);
    exp_cr = put_field(exp_cr, 3, 4'b0010);
    chk("R8 three fields at once", cr_value, exp_cr);
  endtask

  task automatic t_branch();
    for (int i = 0; i < 32; i++) begin
      br_valid = 1; br_bit = 5'(i); step();
      chk("R9 resolved R11", {31'd0, br_resolved}, 1);
      chk($sformatf("R9 bit %0d R2", i), {31'd0, br_taken}, {31'd0, exp_cr[31-i]});
    end
    step();
    chk("R11 idle resolved", {31'd0, br_resolved}, 0);
    chk("R11 idle taken", {31'd0, br_taken}, 0);
    // field 4 holds zero; write its LT bit (bit 16) in the same cycle the branch tests it
    br_valid = 1; br_bit = 16;
    cmp_valid = 1; cmp_field = 4; cmp_signed = 1; cmp_a = 0; cmp_b = 1; step();
    exp_cr = put_field(exp_cr, 4, 4'b1000);
    chk("R9 sees pre-write value", {31'd0, br_taken}, 0);
    br_valid = 1; br_bit = 16; step();
    chk("R9 sees new value", {31'd0, br_taken}, 1);
  endtask

  task automatic t_uncond();
    br_valid = 1; br_uncond = 1; br_bit = 17; step();
    chk("R10 uncond on zero bit", {31'd0, br_taken}, 1);
    rst = 1; @(negedge clk); rst = 0;
    exp_cr = 0;
    chk("R1 second reset", cr_value, 0);
    br_valid = 1; br_uncond = 1; br_bit = 0; step();
    chk("R10 uncond empty register", {31'd0, br_taken}, 1);
  endtask

  initial begin
    t_reset();
    t_record();
    t_fpx();
    t_compare();
    t_priority();
    t_branch();
    t_uncond();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule